// File: doc/BRIEF.md
# Programmable UART Receive Deframer

This block recovers characters from an asynchronous serial receive line. A one-cycle enable pulse arriving at sixteen times the bit rate paces it. The line first passes through a short synchronizer. A falling edge on an idle line opens a frame. The block then checks the start bit at its middle and samples each later bit at its centre. The recovered character is delivered together with its error flags.

A single 8-bit line-control byte sets the frame format, and the transmitter on the same link reads the same byte. The receiver checks parity in every mode the byte can select. For the forced mark and forced space modes, the receiver requires the fixed parity value. The byte is captured when a start edge is seen, so changing it in the middle of a frame does not disturb the character being received. Baud generation, buffering, interrupts and any register interface belong to the surrounding logic.

Top module: `uart_rx_deframer`

## Requirements
- R1: While reset is asserted and after it is released, the outputs `rx_valid`, `parity_err`, `frame_err` and `break_det` are 0, and `rx_data` is 0.
- R2: The field `line_ctl[1:0]` sets the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. The first data bit received is the least significant bit. `rx_data` bits above the length are 0.
- R3: When `line_ctl[3]` is 0, no parity bit is expected, the stop bit follows the data directly, and `parity_err` stays 0. When `line_ctl[3]` is 1, one parity bit follows the data and is checked.
- R4: With `line_ctl[3]`=1 and `line_ctl[5]`=0, setting `line_ctl[4]`=0 requires an odd count of ones across the data and parity bits, and `line_ctl[4]`=1 requires an even count. A mismatch sets `parity_err`.
- R5: With `line_ctl[3]`=1 and `line_ctl[5]`=1, the parity bit must be 1 when `line_ctl[4]`=0 and must be 0 when `line_ctl[4]`=1. Any other value sets `parity_err`.
- R6: A low pulse that has returned to 1 by the middle of the start bit (8 ticks after the edge) is discarded. It produces no `rx_valid`.
- R7: If the first stop bit reads 0, `frame_err` is set along with the character.
- R8: When the data bits, the parity bit (if enabled) and the stop bit all read 0, `break_det` is set, and `frame_err` is also set. No new frame starts until the line has gone back to 1.
- R9: `rx_valid` is high for exactly one clock per character. `rx_data` and all three flags are presented in that same clock, and the flags are 0 whenever `rx_valid` is 0.
- R10: The control byte is captured at the start edge, so a change during a frame does not affect that frame. `line_ctl[7:6]` have no effect on reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Enable pulse, 16 per bit time |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| line_ctl | input | 8 | Shared line-control byte |
| rx_data | output | 8 | Received character, zero-extended |
| rx_valid | output | 1 | One-clock character strobe |
| parity_err | output | 1 | Parity mismatch for this character |
| frame_err | output | 1 | First stop bit read as 0 |
| break_det | output | 1 | Line held at 0 for the whole frame |

## Verification
The hardest condition to reach is the recovery after a break. The line has to stay low well beyond a full frame, and the block must then report exactly one character rather than a stream of them. The stimulus holds the line at 0 for many bit times and counts every strobe during that time. It then releases the line and sends a normal frame, which shows that the block re-armed only on the return to 1. A second hard case is a framing error whose stop bit is cut short. The low tail that follows must be rejected as a false start and must not produce a phantom character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRKW
  } rx_state_e;

  typedef struct packed {
    logic       force_par;
    logic       par_sel;
    logic       par_en;
    logic [1:0] len;
  } rx_cfg_t;

  function automatic rx_cfg_t decode_ctl(input logic [7:0] ctl);
    rx_cfg_t c;
    c.len       = ctl[1:0];
    c.par_en    = ctl[3];
    c.par_sel   = ctl[4];
    c.force_par = ctl[5];
    return c;
  endfunction

  // Index of the last data bit: 4..7
  function automatic logic [2:0] last_bit(input logic [1:0] len);
    return 3'd4 + {1'b0, len};
  endfunction

  // Parity value the line must carry for a given character
  function automatic logic want_parity(input logic [7:0] d, input rx_cfg_t c);
    if (c.force_par) return ~c.par_sel;
    if (c.par_sel)   return ^d;
    return ~(^d);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[0] <= 1'b1;
          else        pipe_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[g] <= 1'b1;
          else        pipe_q[g] <= pipe_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_tick_counter.sv
module rx_tick_counter #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic at_half,
  output logic at_full
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVERSAMPLE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign at_half = tick && (cnt_q == HALF_M1);
  assign at_full = tick && (cnt_q == FULL_M1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (at_full) cnt_d = '0;
    else if (tick)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rx_frame_check.sv
module rx_frame_check
  import uart_rx_pkg::*;
(
  input  rx_cfg_t    cfg,
  input  logic [7:0] data,
  input  logic       par_bit,
  input  logic       stop_bit,
  output logic       par_bad,
  output logic       frm_bad,
  output logic       brk
);
  always_comb begin
    par_bad = cfg.par_en && (par_bit != want_parity(data, cfg));
    frm_bad = ~stop_bit;
    brk     = (data == 8'h00) && ~stop_bit && (~cfg.par_en || ~par_bit);
  end
endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_in,
  input  logic [7:0] line_ctl,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       parity_err,
  output logic       frame_err,
  output logic       break_det
);
  rx_state_e  state_q, state_d;
  rx_cfg_t    cfg_q, cfg_d;
  logic [7:0] shreg_q, shreg_d;
  logic [2:0] bidx_q, bidx_d;
  logic       par_q, par_d;
  logic [7:0] data_q, data_d;
  logic       valid_q, valid_d;
  logic       pe_q, pe_d, fe_q, fe_d, bk_q, bk_d;

  logic rx_s, at_half, at_full, cnt_clr;
  logic chk_pe, chk_fe, chk_bk;

  rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_s)
  );

  rx_tick_counter #(.OVERSAMPLE(OVERSAMPLE)) i_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(cnt_clr),
    .at_half(at_half), .at_full(at_full)
  );

  rx_frame_check i_chk (
    .cfg(cfg_q), .data(shreg_q), .par_bit(par_q), .stop_bit(rx_s),
    .par_bad(chk_pe), .frm_bad(chk_fe), .brk(chk_bk)
  );

  assign cnt_clr = (state_q == ST_IDLE) || (state_q == ST_BRKW) ||
                   ((state_q == ST_START) && at_half);

  always_comb begin
    state_d = state_q;
    cfg_d   = cfg_q;
    shreg_d = shreg_q;
    bidx_d  = bidx_q;
    par_d   = par_q;
    data_d  = data_q;
    valid_d = 1'b0;
    pe_d    = 1'b0;
    fe_d    = 1'b0;
    bk_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tick && !rx_s) begin
          state_d = ST_START;
          cfg_d   = decode_ctl(line_ctl);
          shreg_d = '0;
          bidx_d  = '0;
          par_d   = 1'b0;
        end
      end
      ST_START: begin
        if (at_half) state_d = rx_s ? ST_IDLE : ST_DATA;
      end
      ST_DATA: begin
        if (at_full) begin
          shreg_d[bidx_q] = rx_s;
          bidx_d          = bidx_q + 1'b1;
          if (bidx_q == last_bit(cfg_q.len))
            state_d = cfg_q.par_en ? ST_PAR : ST_STOP;
        end
      end
      ST_PAR: begin
        if (at_full) begin
          par_d   = rx_s;
          state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (at_full) begin
          data_d  = shreg_q;
          valid_d = 1'b1;
          pe_d    = chk_pe;
          fe_d    = chk_fe;
          bk_d    = chk_bk;
          state_d = chk_bk ? ST_BRKW : ST_IDLE;
        end
      end
      ST_BRKW: begin
        if (rx_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      shreg_q <= '0;
      bidx_q  <= '0;
      par_q   <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      bk_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
      shreg_q <= shreg_d;
      bidx_q  <= bidx_d;
      par_q   <= par_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      pe_q    <= pe_d;
      fe_q    <= fe_d;
      bk_q    <= bk_d;
    end
  end

  assign rx_data    = data_q;
  assign rx_valid   = valid_q;
  assign parity_err = pe_q;
  assign frame_err  = fe_q;
  assign break_det  = bk_q;
endmodule

// File: rtl/uart_rx_deframer_chk.sv
module uart_rx_deframer_chk
  import uart_rx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       parity_err,
  input logic       frame_err,
  input logic       break_det,
  input rx_cfg_t    cfg_q
);
  // R9: one-clock strobe
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R9: flags only accompany a character
  a_r9_flags_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (parity_err || frame_err || break_det) |-> rx_valid);

  // R8: a break is always also a framing error and carries zero data
  a_r8_break_is_frame: assert property (@(posedge clk) disable iff (!rst_n)
    break_det |-> (frame_err && rx_data == 8'h00));

  // R3: no parity error when parity is disabled
  a_r3_no_par_err: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_q.par_en) |-> !parity_err);

  // R2: zero extension above the configured length
  a_r2_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> (5 + int'(cfg_q.len))) == 8'h00));
endmodule

bind uart_rx_deframer uart_rx_deframer_chk i_deframer_chk (
  .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
  .parity_err(parity_err), .frame_err(frame_err), .break_det(break_det),
  .cfg_q(cfg_q)
);

// File: tb/test_uart_rx_deframer.sv
module test_uart_rx_deframer;
  localparam int BIT_CLKS = 64;   // 16 ticks x 4 clocks

  logic       clk, rst_n, tick, rx_in;
  logic [7:0] line_ctl;
  logic [7:0] rx_data;
  logic       rx_valid, parity_err, frame_err, break_det;

  int n_chk = 0, n_bad = 0, n_valid = 0;
  logic [7:0] cap_d;
  logic cap_pe, cap_fe, cap_bk;
  logic [1:0] divcnt;
  bit done = 0;

  uart_rx_deframer i_uart_rx_deframer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in), .line_ctl(line_ctl),
    .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err),
    .frame_err(frame_err), .break_det(break_det)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin divcnt <= '0; tick <= 1'b0; end
    else begin divcnt <= divcnt + 1'b1; tick <= (divcnt == 2'd3); end
  end

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      n_valid++;
      cap_d = rx_data; cap_pe = parity_err; cap_fe = frame_err; cap_bk = break_det;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_par(input logic [7:0] d, input int n,
                                 input bit sel, input bit frc);
    int ones;
    ones = $countones(d & 8'((1 << n) - 1));
    if (frc) return !sel;
    if (sel) return bit'(ones % 2);
    return !bit'(ones % 2);
  endfunction

  task automatic idle(input int clks);
    repeat (clks) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int n, input bit par_on,
                      input bit pbit, input bit sbit, input int stop_clks);
    @(negedge clk); rx_in = 0; idle(BIT_CLKS);
    for (int i = 0; i < n; i++) begin rx_in = d[i]; idle(BIT_CLKS); end
    if (par_on) begin rx_in = pbit; idle(BIT_CLKS); end
    rx_in = sbit; idle(stop_clks);
    rx_in = 1; idle(2 * BIT_CLKS);
  endtask

  task automatic expect_one(input string req, input logic [7:0] d,
                            input bit pe, input bit fe, input bit bk);
    chk(n_valid == 1, req, "strobe count", n_valid, 1);
    chk(cap_d == d, req, "data", cap_d, d);
    chk(cap_pe == pe, req, "parity_err", cap_pe, pe);
    chk(cap_fe == fe, req, "frame_err", cap_fe, fe);
    chk(cap_bk == bk, req, "break_det", cap_bk, bk);
    n_valid = 0;
  endtask

  task automatic t_reset;
    idle(3);
    chk(!rx_valid && !parity_err && !frame_err && !break_det, "R1", "flags",
        {rx_valid, parity_err, frame_err, break_det}, 0);
    chk(rx_data == 0, "R1", "data", rx_data, 0);
  endtask

  task automatic t_lengths;  // R2, R3
    for (int n = 5; n <= 8; n++) begin
      line_ctl = 8'(n - 5);
      send(8'hB5, n, 0, 0, 1, BIT_CLKS);
      expect_one("R2", 8'hB5 & 8'((1 << n) - 1), 0, 0, 0);
    end
  endtask

  task automatic t_parity;  // R4, R5
    logic [7:0] pats [3] = '{8'h5A, 8'h01, 8'h7F};
    for (int m = 0; m < 4; m++) begin
      bit sel = m[0], frc = m[1];
      line_ctl = {2'b00, frc, sel, 1'b1, 1'b0, 2'b11};
      foreach (pats[k]) begin
        bit p = exp_par(pats[k], 8, sel, frc);
        send(pats[k], 8, 1, p, 1, BIT_CLKS);
        expect_one(frc ? "R5" : "R4", pats[k], 0, 0, 0);
        send(pats[k], 8, 1, !p, 1, BIT_CLKS);
        expect_one(frc ? "R5" : "R4", pats[k], 1, 0, 0);
      end
    end
    line_ctl = 8'b0000_1010;  // 7 bits, odd
    send(8'h00, 7, 1, exp_par(8'h00, 7, 0, 0), 1, BIT_CLKS);
    expect_one("R4", 8'h00, 0, 0, 0);
  endtask

  task automatic t_false_start;  // R6
    line_ctl = 8'h03;
    @(negedge clk); rx_in = 0; idle(12); rx_in = 1; idle(3 * BIT_CLKS);
    chk(n_valid == 0, "R6", "glitch strobes", n_valid, 0);
    send(8'h3C, 8, 0, 0, 1, BIT_CLKS);
    expect_one("R6", 8'h3C, 0, 0, 0);
  endtask

  task automatic t_framing;  // R7
    line_ctl = 8'h03;
    send(8'hA1, 8, 0, 0, 0, 40);
    expect_one("R7", 8'hA1, 0, 1, 0);
    send(8'h42, 8, 0, 0, 1, BIT_CLKS);
    expect_one("R7", 8'h42, 0, 0, 0);
  endtask

  task automatic t_break;  // R8
    line_ctl = 8'h1B;  // 8 bits, even parity
    @(negedge clk); rx_in = 0; idle(25 * BIT_CLKS);
    expect_one("R8", 8'h00, 0, 1, 1);
    idle(10 * BIT_CLKS);
    chk(n_valid == 0, "R8", "strobes while held low", n_valid, 0);
    rx_in = 1; idle(2 * BIT_CLKS);
    send(8'h99, 8, 1, exp_par(8'h99, 8, 1, 0), 1, BIT_CLKS);
    expect_one("R8", 8'h99, 0, 0, 0);
  endtask

  task automatic t_ctl;  // R10, R9
    line_ctl = 8'hC3;
    send(8'hE7, 8, 0, 0, 1, BIT_CLKS);
    expect_one("R10", 8'hE7, 0, 0, 0);
    line_ctl = 8'h03;
    fork
      send(8'hD2, 8, 0, 0, 1, BIT_CLKS);
      begin idle(3 * BIT_CLKS); line_ctl = 8'h08; end
    join
    expect_one("R10", 8'hD2, 0, 0, 0);
    idle(2);
    chk(!rx_valid && !parity_err && !frame_err && !break_det, "R9", "idle flags",
        {rx_valid, parity_err, frame_err, break_det}, 0);
  endtask

  initial begin
    rst_n = 0; rx_in = 1; line_ctl = 8'h00;
    idle(5);
    chk(!rx_valid && rx_data == 0, "R1", "in reset", {rx_valid, rx_data}, 0);
    rst_n = 1;
    t_reset();
    t_lengths();
    t_parity();
    t_false_start();
    t_framing();
    t_break();
    t_ctl();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule